// File: doc/BRIEF.md
# Interrupt Sequencer for a Small 8-bit Controller

This block is the interrupt control of a compact 8-bit controller with a 10-bit program counter. It holds the single interrupt-enable bit and decides, at each instruction boundary, whether the external request line pre-empts the next instruction. When a request is accepted, three things happen together. The fetch logic is redirected to the top of program space. The address that would have executed next is captured, along with the carry and zero flags. A one-cycle acknowledge is raised towards the requester.

The instruction decoder reports its own events to the block:

- the boundary strobe;
- the enable-interrupt and disable-interrupt operations;
- the return-from-interrupt operation, with a bit that selects whether interrupts come back on.

On a return, the block redirects fetch to the saved address and hands the saved flags back to the ALU. It then sets the enable bit from the return's option bit. All outputs are registered, so every decision appears one clock after the boundary that caused it.

Top module: `isq_sequencer`

## Requirements
- R1: While `int_enable` is 0, a high `irq_in` never produces `irq_ack` or a vector load, whatever `step` does.
- R2: On a cycle with `step`=1, `op_ei` sets `int_enable` and `op_di` clears it, with clear winning when both are high. With `step`=0 these operations have no effect.
- R3: A request is accepted when `step`=1, `irq_in`=1 and `int_enable`=1. In the next cycle `pc_load`=1 and `pc_target` is all ones (0x3FF for 10 bits).
- R4: Accepting a request clears `int_enable` in the same update. Accepting also overrides any `op_ei`, `op_di` or `op_reti` presented in that boundary.
- R5: A `op_reti` at a boundary that does not accept a request gives, in the next cycle, `pc_load`=1 with `pc_target` equal to the `pc_next` value captured at the last acceptance.
- R6: After a return, `int_enable` equals the `reti_en` bit of that return: 1 re-enables and 0 leaves interrupts off.
- R7: `c_in` and `z_in` are captured at acceptance. On return, `flag_restore` pulses for one cycle while `c_out`/`z_out` carry the captured values.
- R8: `irq_ack` is high for exactly one cycle, the cycle in which the vector load is presented. A request held high does not produce a second acknowledge until interrupts are enabled again.
- R9: `irq_in` is looked at only when `step`=1 and is not latched. A request that goes away before a boundary with interrupts enabled is lost.
- R10: While `rst` is high, the next cycle shows `pc_load`=1, `pc_target`=0x000, `irq_ack`=0, `flag_restore`=0 and `int_enable`=0. The saved address and flags are also cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 1 | External interrupt request, level |
| step | input | 1 | Instruction boundary strobe |
| op_ei | input | 1 | Enable-interrupt instruction decoded |
| op_di | input | 1 | Disable-interrupt instruction decoded |
| op_reti | input | 1 | Return-from-interrupt instruction decoded |
| reti_en | input | 1 | Re-enable option of the return instruction |
| pc_next | input | ADDR_W | Address of the instruction about to execute |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| pc_load | output | 1 | Force the program counter to `pc_target` |
| pc_target | output | ADDR_W | Redirect address |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| flag_restore | output | 1 | Load `c_out`/`z_out` into the ALU flags |
| c_out | output | 1 | Restored carry flag |
| z_out | output | 1 | Restored zero flag |
| int_enable | output | 1 | Interrupt-enable flag |

## Verification
Directed sequences apply a request while interrupts are disabled, a request that arrives between boundaries, and a request held across many boundaries. Together these separate a correct level-sampled, self-disabling acceptance from one that latches requests, samples off-boundary, or acknowledges twice. Collisions of a request with enable, disable and return operations in one boundary show whether acceptance takes priority. Returns with the option bit set and clear show whether the address, the flags and the enable bit are each restored from the right source. A long pseudo-random stretch of mixed operations, with resets inside it, is compared every cycle against a behavioural model.

// File: rtl/isq_pkg.sv
`timescale 1ns/1ps
package isq_pkg;
  // Decision taken at one instruction boundary, in priority order.
  typedef enum logic [1:0] {
    ISQ_IDLE   = 2'd0,
    ISQ_TAKE   = 2'd1,
    ISQ_RETURN = 2'd2,
    ISQ_FLAGOP = 2'd3
  } isq_act_e;
endpackage

// File: rtl/isq_arbiter.sv
`timescale 1ns/1ps
module isq_arbiter
  import isq_pkg::*;
(
  input  logic     step,
  input  logic     irq_in,
  input  logic     ie,
  input  logic     op_ei,
  input  logic     op_di,
  input  logic     op_reti,
  output isq_act_e act
);
  // Acceptance pre-empts whatever instruction sits at the boundary.
  always_comb begin
    act = ISQ_IDLE;
    if (step) begin
      if (irq_in && ie)       act = ISQ_TAKE;
      else if (op_reti)       act = ISQ_RETURN;
      else if (op_ei || op_di) act = ISQ_FLAGOP;
    end
  end
endmodule

// File: rtl/isq_enable_flag.sv
`timescale 1ns/1ps
module isq_enable_flag
  import isq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  isq_act_e act,
  input  logic     op_ei,
  input  logic     op_di,
  input  logic     reti_en,
  output logic     ie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie <= 1'b0;
    end else begin
      case (act)
        ISQ_TAKE:   ie <= 1'b0;
        ISQ_RETURN: ie <= reti_en;
        ISQ_FLAGOP: begin
          if (op_di)      ie <= 1'b0;
          else if (op_ei) ie <= 1'b1;
        end
        default:    ie <= ie;
      endcase
    end
  end

  p_take_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (act == ISQ_TAKE) |=> !ie);
  p_reti_option_r6: assert property (@(posedge clk) disable iff (rst)
    (act == ISQ_RETURN) |=> (ie == $past(reti_en)));
  p_di_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (act == ISQ_FLAGOP && op_di) |=> !ie);
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (act == ISQ_IDLE) |=> $stable(ie));
endmodule

// File: rtl/isq_context.sv
`timescale 1ns/1ps
module isq_context
  import isq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  isq_act_e          act,
  input  logic [ADDR_W-1:0] pc_next,
  input  logic              c_in,
  input  logic              z_in,
  output logic [ADDR_W-1:0] saved_pc,
  output logic              saved_c,
  output logic              saved_z
);
  always_ff @(posedge clk) begin
    if (rst) begin
      saved_pc <= '0;
      saved_c  <= 1'b0;
      saved_z  <= 1'b0;
    end else if (act == ISQ_TAKE) begin
      saved_pc <= pc_next;
      saved_c  <= c_in;
      saved_z  <= z_in;
    end
  end

  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (act == ISQ_TAKE) |=> (saved_c == $past(c_in) && saved_z == $past(z_in)
                           && saved_pc == $past(pc_next)));
  p_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (act != ISQ_TAKE) |=> $stable(saved_pc));
endmodule

// File: rtl/isq_redirect.sv
`timescale 1ns/1ps
module isq_redirect
  import isq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  isq_act_e          act,
  input  logic [ADDR_W-1:0] saved_pc,
  input  logic              saved_c,
  input  logic              saved_z,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_target,
  output logic              irq_ack,
  output logic              flag_restore,
  output logic              c_out,
  output logic              z_out
);
  localparam logic [ADDR_W-1:0] VECTOR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOOT   = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load      <= 1'b1;
      pc_target    <= BOOT;
      irq_ack      <= 1'b0;
      flag_restore <= 1'b0;
      c_out        <= 1'b0;
      z_out        <= 1'b0;
    end else begin
      pc_load      <= 1'b0;
      irq_ack      <= 1'b0;
      flag_restore <= 1'b0;
      case (act)
        ISQ_TAKE: begin
          pc_load   <= 1'b1;
          pc_target <= VECTOR;
          irq_ack   <= 1'b1;
        end
        ISQ_RETURN: begin
          pc_load      <= 1'b1;
          pc_target    <= saved_pc;
          flag_restore <= 1'b1;
          c_out        <= saved_c;
          z_out        <= saved_z;
        end
        default: ;
      endcase
    end
  end

  p_ack_vector_r3: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (pc_load && pc_target == VECTOR));
  p_ack_single_r8: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);
  p_restore_loads_r5: assert property (@(posedge clk) disable iff (rst)
    flag_restore |-> (pc_load && !irq_ack));
  p_restore_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    flag_restore |=> !flag_restore || $past(act == ISQ_RETURN));
endmodule

// File: rtl/isq_sequencer.sv
`timescale 1ns/1ps
module isq_sequencer
  import isq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_in,
  input  logic              step,
  input  logic              op_ei,
  input  logic              op_di,
  input  logic              op_reti,
  input  logic              reti_en,
  input  logic [ADDR_W-1:0] pc_next,
  input  logic              c_in,
  input  logic              z_in,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_target,
  output logic              irq_ack,
  output logic              flag_restore,
  output logic              c_out,
  output logic              z_out,
  output logic              int_enable
);
  isq_act_e          act;
  logic [ADDR_W-1:0] saved_pc;
  logic              saved_c;
  logic              saved_z;

  isq_arbiter u_arb (
    .step(step), .irq_in(irq_in), .ie(int_enable),
    .op_ei(op_ei), .op_di(op_di), .op_reti(op_reti), .act(act)
  );

  isq_enable_flag u_ie (
    .clk(clk), .rst(rst), .act(act), .op_ei(op_ei), .op_di(op_di),
    .reti_en(reti_en), .ie(int_enable)
  );

  isq_context #(.ADDR_W(ADDR_W)) u_ctx (
    .clk(clk), .rst(rst), .act(act), .pc_next(pc_next), .c_in(c_in),
    .z_in(z_in), .saved_pc(saved_pc), .saved_c(saved_c), .saved_z(saved_z)
  );

  isq_redirect #(.ADDR_W(ADDR_W)) u_redir (
    .clk(clk), .rst(rst), .act(act), .saved_pc(saved_pc), .saved_c(saved_c),
    .saved_z(saved_z), .pc_load(pc_load), .pc_target(pc_target),
    .irq_ack(irq_ack), .flag_restore(flag_restore), .c_out(c_out), .z_out(z_out)
  );

  p_gated_r1: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(int_enable));
  p_off_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    !step |=> !pc_load);
  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (pc_load && pc_target == '0 && !irq_ack && !int_enable && !flag_restore));
endmodule

// File: tb/tb_isq_sequencer.sv
`timescale 1ns/1ps
module tb_isq_sequencer;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst, irq_in, step, op_ei, op_di, op_reti, reti_en, c_in, z_in;
  logic [AW-1:0] pc_next;
  logic pc_load, irq_ack, flag_restore, c_out, z_out, int_enable;
  logic [AW-1:0] pc_target;

  always #2.5 clk = ~clk;

  isq_sequencer #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .step(step), .op_ei(op_ei),
    .op_di(op_di), .op_reti(op_reti), .reti_en(reti_en), .pc_next(pc_next),
    .c_in(c_in), .z_in(z_in), .pc_load(pc_load), .pc_target(pc_target),
    .irq_ack(irq_ack), .flag_restore(flag_restore), .c_out(c_out),
    .z_out(z_out), .int_enable(int_enable)
  );

  // reference model state
  int m_ie, m_sret, m_sc, m_sz;
  int e_load, e_tgt, e_ack, e_rest, e_c, e_z;
  int n_vec = 0, n_bad = 0;
  bit primed = 0, done = 0;
  string cur_tag = "R10", exp_tag = "R10";

  task automatic cmp(string sig, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", exp_tag, sig, act, exp, $time);
    end
  endtask

  task automatic tick(input bit r, input bit irq, input bit stp, input bit ei,
                      input bit di, input bit ret, input bit ren,
                      input int pc, input bit c, input bit z);
    @(negedge clk);
    if (primed) begin
      cmp("pc_load", int'(pc_load), e_load);
      cmp("pc_target", int'(pc_target), e_tgt);
      cmp("irq_ack", int'(irq_ack), e_ack);
      cmp("flag_restore", int'(flag_restore), e_rest);
      cmp("c_out", int'(c_out), e_c);
      cmp("z_out", int'(z_out), e_z);
      cmp("int_enable", int'(int_enable), m_ie);
    end
    rst = r; irq_in = irq; step = stp; op_ei = ei; op_di = di;
    op_reti = ret; reti_en = ren; pc_next = AW'(pc); c_in = c; z_in = z;
    // behavioural expectation for the state after the coming edge
    if (r) begin
      m_ie = 0; m_sret = 0; m_sc = 0; m_sz = 0;
      e_load = 1; e_tgt = 0; e_ack = 0; e_rest = 0; e_c = 0; e_z = 0;
    end else begin
      e_load = 0; e_ack = 0; e_rest = 0;
      if (stp && irq && m_ie == 1) begin
        e_load = 1; e_ack = 1; e_tgt = (1 << AW) - 1;
        m_sret = pc; m_sc = c; m_sz = z; m_ie = 0;
      end else if (stp && ret) begin
        e_load = 1; e_tgt = m_sret; e_rest = 1; e_c = m_sc; e_z = m_sz;
        m_ie = ren;
      end else if (stp && di) begin
        m_ie = 0;
      end else if (stp && ei) begin
        m_ie = 1;
      end
    end
    exp_tag = cur_tag;
    primed = 1;
  endtask

  // idle boundary with given irq level
  task automatic nop(input bit irq, input bit stp);
    tick(0, irq, stp, 0, 0, 0, 0, 12, 0, 0);
  endtask

  initial begin
    // R10: reset state
    cur_tag = "R10";
    repeat (3) tick(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    nop(0, 1);
    // R1: request ignored while enable flag is clear
    cur_tag = "R1";
    repeat (4) nop(1, 1);
    nop(1, 0);
    // R2: enable/disable, off-boundary ignored, disable wins on collision
    cur_tag = "R2";
    tick(0, 0, 0, 1, 0, 0, 0, 5, 0, 0);
    nop(0, 1);
    tick(0, 0, 1, 1, 0, 0, 0, 5, 0, 0);
    tick(0, 0, 0, 0, 1, 0, 0, 5, 0, 0);
    nop(0, 1);
    tick(0, 0, 1, 0, 1, 0, 0, 5, 0, 0);
    tick(0, 0, 1, 1, 0, 0, 0, 5, 0, 0);
    tick(0, 0, 1, 1, 1, 0, 0, 5, 0, 0);
    tick(0, 0, 1, 1, 0, 0, 0, 5, 0, 0);
    // R9: request between boundaries is not seen; dropped request is lost
    cur_tag = "R9";
    nop(1, 0);
    nop(1, 0);
    nop(0, 1);
    nop(0, 1);
    // R3 / R8: acceptance, vector, single acknowledge while held
    cur_tag = "R3";
    tick(0, 1, 1, 0, 0, 0, 0, 'h123, 1, 0);
    cur_tag = "R8";
    repeat (5) nop(1, 1);
    // R5 / R6 / R7: return with re-enable, flags restored
    cur_tag = "R5";
    tick(0, 0, 1, 0, 0, 1, 1, 'h3FF, 0, 1);
    cur_tag = "R7";
    nop(0, 1);
    nop(0, 1);
    // R4: acceptance overrides simultaneous return and disable
    cur_tag = "R4";
    tick(0, 1, 1, 0, 1, 1, 0, 'h2A5, 0, 1);
    tick(0, 0, 1, 1, 0, 0, 0, 'h001, 0, 0);
    nop(0, 1);
    // R6: return that leaves interrupts off; request then ignored
    cur_tag = "R6";
    tick(0, 0, 1, 0, 0, 1, 0, 'h010, 1, 1);
    nop(1, 1);
    nop(1, 1);
    // R10: reset mid-run clears saved context
    cur_tag = "R10";
    tick(0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    tick(0, 1, 1, 0, 0, 0, 0, 'h055, 1, 1);
    tick(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 1, 0, 0, 1, 0, 'h077, 0, 0);
    nop(0, 0);
    // mixed pseudo-random traffic against the model
    cur_tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      tick(r == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 2) != 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 6) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1023), $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1);
    end
    nop(0, 0);
    nop(0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule